// File: doc/BRIEF.md
# Exception Entry and Return Controller

This unit keeps the small set of system-control state that a processor core touches when it traps and when it comes back from a trap. It holds three status flags (exception level, error level and bootstrap-vector select), the cause fields (exception code, delay-slot flag and coprocessor number), and the two saved return addresses: one for ordinary traps and one for error traps.

On a trap request it records the cause and saves the restart address, unless an earlier trap is still being handled. It then computes the handler vector from the bootstrap select and the refill type, and issues a one-cycle redirect with a pipeline flush. On a return request it picks the saved address that matches the active level, clears that level, pulses a clear for the load-linked reservation and redirects the core. A return attempted outside kernel mode is turned into a coprocessor-unusable trap.

The cause register write path, the interrupt prioritisation and the moves to and from the control registers belong to neighbouring logic. The core supplies the current mode field and the faulting PC.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset, exception level is 0, error level is 1, bootstrap select is 1, the kernel flag is 1, and the redirect, flush and load-linked-clear strobes are 0.
- R2: A trap request writes its 5-bit code into the cause code field and copies the delay-slot input into the cause delay-slot flag. The result is visible on the cycle after the request edge.
- R3: The cause coprocessor field takes the request's 2-bit coprocessor number only when the code is 11 (coprocessor unusable). For every other code it becomes 0.
- R4: When exception level is 0, a trap saves the PC into the return register, or the PC minus 4 when the delay-slot input is 1, and sets exception level.
- R5: When exception level is already 1, a trap leaves the return register unchanged but still updates the cause fields.
- R6: The handler vector is a base plus an offset. The base is 0xBFC00200 when bootstrap select is 1 and 0x80000000 when it is 0. The offset is 0x080 for an extended refill, 0x000 for a plain refill and 0x180 for any other trap.
- R7: A return while error level is 1 redirects to the error return register (reset value ERR_PC) and clears error level.
- R8: A return while error level is 0 redirects to the return register and clears exception level.
- R9: A completed return pulses the load-linked-clear output for one cycle. A trap never does.
- R10: A return request outside kernel mode becomes a trap with code 11 and coprocessor 0, using the current PC and delay-slot input.
- R11: The kernel flag is 1 when the 2-bit mode input is 0, when exception level is 1, or when error level is 1.
- R12: Each trap or return asserts redirect and flush for exactly one cycle, with the redirect PC valid in that cycle.
- R13: When a trap request and a return request arrive in the same cycle, only the trap takes effect.
- R14: A pulse on the boot-exit input clears bootstrap select from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Trap request |
| exc_code | input | 5 | Trap code |
| exc_refill | input | 1 | Trap is a translation refill |
| exc_xrefill | input | 1 | Trap is an extended-address refill |
| exc_cop | input | 2 | Coprocessor number for unusable traps |
| cur_pc | input | 32 | PC of the faulting instruction |
| in_delay | input | 1 | Faulting instruction sits in a delay slot |
| eret_req | input | 1 | Return-from-trap request |
| ksu | input | 2 | Current mode field, 0 = kernel |
| boot_exit | input | 1 | Clears bootstrap vector select |
| redir_pc | output | 32 | Redirect target |
| redir_vld | output | 1 | Redirect strobe |
| flush | output | 1 | Pipeline flush pulse |
| ll_clr | output | 1 | Load-linked clear pulse |
| kernel_mode | output | 1 | Kernel-mode flag |
| st_exl | output | 1 | Exception level |
| st_erl | output | 1 | Error level |
| st_bev | output | 1 | Bootstrap vector select |
| cause_code | output | 5 | Cause code field |
| cause_bd | output | 1 | Cause delay-slot flag |
| cause_ce | output | 2 | Cause coprocessor field |
| epc | output | 32 | Return register |

## Verification
A trap request and a return request can land on the same edge, and the trap must win. The vector table drives both strobes together while exception level is already 1. It then judges the outcome by the general vector on the redirect PC, by the return register left unchanged, by exception level staying set and by the absence of a load-linked clear. A second overlap is a return issued in user mode, which must itself become a trap. The bench judges that case by a code of 11 in the cause field and by the saved PC.

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit #(
  parameter int          AW         = 32,
  parameter logic [31:0] ERR_PC     = 32'hBFC0_0000,
  parameter logic [31:0] BASE_NORM  = 32'h8000_0000,
  parameter logic [31:0] BASE_BOOT  = 32'hBFC0_0200,
  parameter logic [4:0]  CODE_COPU  = 5'd11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_req,
  input  logic [4:0]    exc_code,
  input  logic          exc_refill,
  input  logic          exc_xrefill,
  input  logic [1:0]    exc_cop,
  input  logic [AW-1:0] cur_pc,
  input  logic          in_delay,
  input  logic          eret_req,
  input  logic [1:0]    ksu,
  input  logic          boot_exit,
  output logic [AW-1:0] redir_pc,
  output logic          redir_vld,
  output logic          flush,
  output logic          ll_clr,
  output logic          kernel_mode,
  output logic          st_exl,
  output logic          st_erl,
  output logic          st_bev,
  output logic [4:0]    cause_code,
  output logic          cause_bd,
  output logic [1:0]    cause_ce,
  output logic [AW-1:0] epc
);
  localparam logic [AW-1:0] OFF_REFILL = AW'(32'h000);
  localparam logic [AW-1:0] OFF_XREF   = AW'(32'h080);
  localparam logic [AW-1:0] OFF_GEN    = AW'(32'h180);
  localparam logic [AW-1:0] INST_BYTES = AW'(4);

  logic [AW-1:0] err_epc;

  assign kernel_mode = (ksu == 2'b00) || st_exl || st_erl;

  wire       eret_trap = eret_req && !exc_req && !kernel_mode;
  wire       eret_ok   = eret_req && !exc_req && kernel_mode;
  wire       take_exc  = exc_req || eret_trap;
  wire [4:0] eff_code  = exc_req ? exc_code : CODE_COPU;
  wire [1:0] eff_cop   = exc_req ? exc_cop : 2'd0;
  wire       eff_ref   = exc_req && exc_refill;
  wire       eff_xref  = exc_req && exc_xrefill;

  wire [AW-1:0] vec_base = st_bev ? AW'(BASE_BOOT) : AW'(BASE_NORM);
  wire [AW-1:0] vec_off  = eff_xref ? OFF_XREF : (eff_ref ? OFF_REFILL : OFF_GEN);
  wire [AW-1:0] save_pc  = in_delay ? cur_pc - INST_BYTES : cur_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_exl     <= 1'b0;
      st_erl     <= 1'b1;
      st_bev     <= 1'b1;
      epc        <= '0;
      err_epc    <= AW'(ERR_PC);
      cause_code <= '0;
      cause_bd   <= 1'b0;
      cause_ce   <= '0;
      redir_pc   <= '0;
      redir_vld  <= 1'b0;
      flush      <= 1'b0;
      ll_clr     <= 1'b0;
    end else begin
      redir_vld <= take_exc || eret_ok;
      flush     <= take_exc || eret_ok;
      ll_clr    <= eret_ok;
      if (boot_exit) st_bev <= 1'b0;
      if (take_exc) begin
        cause_code <= eff_code;
        cause_bd   <= in_delay;
        cause_ce   <= (eff_code == CODE_COPU) ? eff_cop : 2'd0;
        if (!st_exl) begin
          epc    <= save_pc;
          st_exl <= 1'b1;
        end
        redir_pc <= vec_base + vec_off;
      end else if (eret_ok) begin
        if (st_erl) begin
          redir_pc <= err_epc;
          st_erl   <= 1'b0;
        end else begin
          redir_pc <= epc;
          st_exl   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          exc_req,
  input logic [4:0]    exc_code,
  input logic          eret_req,
  input logic          redir_vld,
  input logic          flush,
  input logic          ll_clr,
  input logic          kernel_mode,
  input logic          st_exl,
  input logic          st_erl,
  input logic [1:0]    cause_ce,
  input logic [AW-1:0] epc
);
  a_r5_epc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && st_exl) |=> $stable(epc));
  a_r4_exl_set: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> st_exl);
  a_r3_ce_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && exc_code != 5'd11) |=> (cause_ce == 2'd0));
  a_r9_ll_with_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    ll_clr |-> (redir_vld && flush));
  a_r7_erl_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_req && !exc_req && st_erl) |=> !st_erl);
  a_r13_trap_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && eret_req) |=> (!ll_clr && st_exl));
  a_r11_kernel_in_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (st_exl || st_erl) |-> kernel_mode);
endmodule

bind exc_ctrl_unit exc_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
  .eret_req(eret_req), .redir_vld(redir_vld), .flush(flush), .ll_clr(ll_clr),
  .kernel_mode(kernel_mode), .st_exl(st_exl), .st_erl(st_erl),
  .cause_ce(cause_ce), .epc(epc)
);

// File: tb/sim_exc_ctrl_unit.sv
module sim_exc_ctrl_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_req = 1'b0;
  logic [4:0]  exc_code = '0;
  logic        exc_refill = 1'b0;
  logic        exc_xrefill = 1'b0;
  logic [1:0]  exc_cop = '0;
  logic [31:0] cur_pc = '0;
  logic        in_delay = 1'b0;
  logic        eret_req = 1'b0;
  logic [1:0]  ksu = 2'd0;
  logic        boot_exit = 1'b0;
  logic [31:0] redir_pc, epc;
  logic        redir_vld, flush, ll_clr, kernel_mode, st_exl, st_erl, st_bev, cause_bd;
  logic [4:0]  cause_code;
  logic [1:0]  cause_ce;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  exc_ctrl_unit u0 (.*);

  typedef struct packed {
    logic        exc;
    logic [4:0]  code;
    logic        rf;
    logic        xrf;
    logic [1:0]  cop;
    logic [31:0] pc;
    logic        bd;
    logic        eret;
    logic        boot;
    logic [1:0]  mode;
    logic [31:0] x_pc;
    logic [31:0] x_epc;
    logic        x_exl;
    logic        x_erl;
    logic [4:0]  x_code;
    logic [1:0]  x_ce;
    logic        x_bd;
    logic        x_ll;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 5'd0,  1'b0,1'b0,2'd0, 32'h0,          1'b0,1'b1,1'b0,2'd2, 32'hBFC00000, 32'h0,          1'b0,1'b0,5'd0, 2'd0,1'b0,1'b1},
    '{1'b1, 5'd8,  1'b0,1'b0,2'd3, 32'h00400100,   1'b0,1'b0,1'b0,2'd2, 32'hBFC00380, 32'h00400100,   1'b1,1'b0,5'd8, 2'd0,1'b0,1'b0},
    '{1'b1, 5'd11, 1'b0,1'b0,2'd2, 32'h00400200,   1'b1,1'b0,1'b0,2'd2, 32'hBFC00380, 32'h00400100,   1'b1,1'b0,5'd11,2'd2,1'b1,1'b0},
    '{1'b0, 5'd0,  1'b0,1'b0,2'd0, 32'h0,          1'b0,1'b1,1'b0,2'd2, 32'h00400100, 32'h00400100,   1'b0,1'b0,5'd11,2'd2,1'b1,1'b1},
    '{1'b0, 5'd0,  1'b0,1'b0,2'd0, 32'h00400300,   1'b0,1'b1,1'b0,2'd2, 32'hBFC00380, 32'h00400300,   1'b1,1'b0,5'd11,2'd0,1'b0,1'b0},
    '{1'b0, 5'd0,  1'b0,1'b0,2'd0, 32'h0,          1'b0,1'b1,1'b1,2'd2, 32'h00400300, 32'h00400300,   1'b0,1'b0,5'd11,2'd0,1'b0,1'b1},
    '{1'b1, 5'd2,  1'b1,1'b0,2'd0, 32'h00001000,   1'b1,1'b0,1'b0,2'd2, 32'h80000000, 32'h00000FFC,   1'b1,1'b0,5'd2, 2'd0,1'b1,1'b0},
    '{1'b1, 5'd3,  1'b1,1'b1,2'd0, 32'h00002000,   1'b0,1'b0,1'b0,2'd2, 32'h80000080, 32'h00000FFC,   1'b1,1'b0,5'd3, 2'd0,1'b0,1'b0},
    '{1'b1, 5'd4,  1'b0,1'b0,2'd1, 32'h00003000,   1'b0,1'b1,1'b0,2'd0, 32'h80000180, 32'h00000FFC,   1'b1,1'b0,5'd4, 2'd0,1'b0,1'b0},
    '{1'b0, 5'd0,  1'b0,1'b0,2'd0, 32'h0,          1'b0,1'b1,1'b0,2'd0, 32'h00000FFC, 32'h00000FFC,   1'b0,1'b0,5'd4, 2'd0,1'b0,1'b1},
    '{1'b1, 5'd11, 1'b0,1'b0,2'd1, 32'h00004000,   1'b0,1'b0,1'b0,2'd2, 32'h80000180, 32'h00004000,   1'b1,1'b0,5'd11,2'd1,1'b0,1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    exc_req = 0; eret_req = 0; boot_exit = 0; exc_refill = 0; exc_xrefill = 0;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    ksu = 2'd2;
    @(negedge clk);
    chk("R1 exl", {31'd0, st_exl}, 32'd0);
    chk("R1 erl", {31'd0, st_erl}, 32'd1);
    chk("R1 bev", {31'd0, st_bev}, 32'd1);
    chk("R1 kernel", {31'd0, kernel_mode}, 32'd1);
    chk("R1 strobes", {29'd0, redir_vld, flush, ll_clr}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      exc_req = TBL[i].exc; exc_code = TBL[i].code; exc_refill = TBL[i].rf;
      exc_xrefill = TBL[i].xrf; exc_cop = TBL[i].cop; cur_pc = TBL[i].pc;
      in_delay = TBL[i].bd; eret_req = TBL[i].eret; boot_exit = TBL[i].boot;
      ksu = TBL[i].mode;
      @(negedge clk);
      chk($sformatf("R6/R7/R8 redirect pc row %0d", i), redir_pc, TBL[i].x_pc);
      chk($sformatf("R12 strobes row %0d", i), {30'd0, redir_vld, flush}, 32'd3);
      chk($sformatf("R4/R5 epc row %0d", i), epc, TBL[i].x_epc);
      chk($sformatf("R4/R8 exl row %0d", i), {31'd0, st_exl}, {31'd0, TBL[i].x_exl});
      chk($sformatf("R7 erl row %0d", i), {31'd0, st_erl}, {31'd0, TBL[i].x_erl});
      chk($sformatf("R2/R10 code row %0d", i), {27'd0, cause_code}, {27'd0, TBL[i].x_code});
      chk($sformatf("R3 ce row %0d", i), {30'd0, cause_ce}, {30'd0, TBL[i].x_ce});
      chk($sformatf("R2 bd row %0d", i), {31'd0, cause_bd}, {31'd0, TBL[i].x_bd});
      chk($sformatf("R9/R13 llclr row %0d", i), {31'd0, ll_clr}, {31'd0, TBL[i].x_ll});
      if (i == 5) chk("R14 bev cleared", {31'd0, st_bev}, 32'd0);
      idle();
    end

    // R12: strobes drop after one cycle
    @(negedge clk);
    chk("R12 strobes low", {29'd0, redir_vld, flush, ll_clr}, 32'd0);

    // R11: kernel flag with exl=1 and any mode, then user after return
    ksu = 2'd2;
    #1 chk("R11 kernel via exl", {31'd0, kernel_mode}, 32'd1);
    eret_req = 1; ksu = 2'd0;
    @(negedge clk);
    idle();
    ksu = 2'd2;
    #1 chk("R11 user mode", {31'd0, kernel_mode}, 32'd0);
    ksu = 2'd0;
    #1 chk("R11 kernel via ksu", {31'd0, kernel_mode}, 32'd1);
    chk("R8 exl cleared", {31'd0, st_exl}, 32'd0);

    // R1: reset again restores bev and erl
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    chk("R1 bev after rereset", {31'd0, st_bev}, 32'd1);
    chk("R1 erl after rereset", {31'd0, st_erl}, 32'd1);
    // R6: refill with bev=1 goes to boot base
    exc_req = 1; exc_code = 5'd2; exc_refill = 1; exc_xrefill = 0; cur_pc = 32'h100; in_delay = 0;
    @(negedge clk);
    idle();
    chk("R6 boot refill vector", redir_pc, 32'hBFC00200);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule